// File: doc/BRIEF.md
# Coprocessor Bus Slave Front End

This block is the host-facing front end of a numeric coprocessor that shares a host CPU's 32-bit local bus. It watches a stack enable, two select lines and two function lines. It recognises bus cycles meant for the coprocessor by an address-start strobe seen with a valid select, and holds each such cycle open until the end-of-cycle strobe. Each accepted cycle falls into one of four kinds: a control or status word read, an opcode write, an operand read or an operand write. Read data goes out on a 32-bit read bus with its own drive enable. The pad ring combines that read bus with the write bus into the shared bidirectional bus.

Two handshakes go back to the host. The busy flag rises when an opcode write delivers a new instruction. It falls when the execution engine reports completion. The operand request tells the host that the operand FIFO can take or give a word. It stays up until the number of operand words announced with the opcode has moved. The execution engine, the register stack and the operand FIFO lie outside the block and connect through stub ports.

The low select line is active low. A system can drive it from the inverted top address bit of I/O cycles, so that the coprocessor sits in a reserved I/O space. When the stack enable is low, both pad-enable outputs are low, so the pad ring floats every output of the block.

Top module: `cpbus_slave`

## Requirements
- R1: With `stack_en_i`=0, `ctl_oe_o` and `data_oe_o` are both 0 in the same cycle, even inside an open read cycle. With `stack_en_i`=1, `ctl_oe_o` is 1.
- R2: A rising clock edge opens a cycle only if there is no open cycle and, at that edge, `start_i`=1, `stack_en_i`=1, `sel_lo_n_i`=0 and `sel_hi_i`=1. Any other select pattern causes no transfer: no `op_vld_o`, `push_o` or `pop_o` pulse, and no change to `busy_o`.
- R3: The cycle kind is {`fn_cmd_i`,`fn_wr_i`}: 00 is a control/status read, 01 an opcode write, 10 an operand read and 11 an operand write. The kind is captured at the opening edge. Changes on the function lines before the cycle closes have no effect.
- R4: An open cycle closes at the first rising edge with `done_i`=1. A `done_i` pulse with no open cycle has no effect. Any number of wait cycles may pass before `done_i`.
- R5: `data_oe_o` is 1 from the cycle after the opening edge up to and including the closing edge, and only for read kinds (`fn_wr_i`=0). While it is 1, `rd_data_o` carries `stat_word_i` for kind 00 and `fifo_word_i` for kind 10.
- R6: An opcode write that closes while `busy_o`=0 does three things in the cycle after the closing edge. It pulses `op_vld_o` for one cycle with `op_word_o` = `wr_data_i` as sampled at that edge. It raises `busy_o`. It loads the remaining operand count from `opnd_need_i`.
- R7: `busy_o` falls at the rising edge where `exec_done_i`=1.
- R8: In the cycle after a closing edge, an operand write pulses `push_o` for one cycle with `push_word_o` = `wr_data_i` as sampled at that edge. An operand read pulses `pop_o` for one cycle. Either kind decrements a nonzero remaining count by one.
- R9: `opnd_req_o` is 1 exactly when the remaining count is nonzero and `fifo_rdy_i`=1.
- R10: An opcode write that closes while `busy_o`=1 sets `proto_err_o`, which stays set until reset. The write does not pulse `op_vld_o` and leaves the busy flag and the remaining count unchanged.
- R11: After reset, `busy_o`, `opnd_req_o`, `proto_err_o`, `op_vld_o`, `push_o`, `pop_o` and `data_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stack_en_i | input | 1 | Stack enable; low floats all outputs |
| sel_lo_n_i | input | 1 | Active-low select (inverted top I/O address bit) |
| sel_hi_i | input | 1 | Active-high select |
| fn_cmd_i | input | 1 | Function line: 0 control/opcode, 1 operand |
| fn_wr_i | input | 1 | Direction: 0 read, 1 write |
| start_i | input | 1 | Address-start strobe, active high |
| done_i | input | 1 | End-of-cycle strobe, active high |
| wr_data_i | input | 32 | Write half of the local data bus |
| rd_data_o | output | 32 | Read half of the local data bus |
| data_oe_o | output | 1 | Drive enable for the data bus pads |
| ctl_oe_o | output | 1 | Drive enable for the handshake pads |
| stat_word_i | input | 32 | Control/status word from the engine stub |
| fifo_word_i | input | 32 | Head word of the operand FIFO stub |
| fifo_rdy_i | input | 1 | Operand FIFO can move a word |
| opnd_need_i | input | 3 | Operand words the new opcode needs |
| exec_done_i | input | 1 | Engine finished the current instruction |
| op_word_o | output | 32 | Delivered opcode word |
| op_vld_o | output | 1 | One-cycle opcode delivery pulse |
| push_word_o | output | 32 | Operand word written by the host |
| push_o | output | 1 | One-cycle operand push pulse |
| pop_o | output | 1 | One-cycle operand pop pulse |
| busy_o | output | 1 | Instruction in progress |
| opnd_req_o | output | 1 | Operand transfer request |
| proto_err_o | output | 1 | Sticky opcode-while-busy error |

## Verification
The embedded properties check on every cycle that:
- a cycle opens only with a valid select and then keeps its kind until it closes;
- the end strobe always closes an open cycle;
- the drive enable rises only after an opening strobe, and both enables fall with the stack enable;
- busy rises only through an opcode close and falls on engine completion;
- the remaining operand count steps down by one per operand transfer;
- the error flag never clears.

Only the bench's scenarios show the rest. The full sweep of select and function patterns shows which patterns produce which transfers and which read source appears on the bus. Directed scenarios show that a mid-cycle change of the function lines is ignored, that a stray end strobe does nothing, and that an opcode write while busy is dropped.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

  // Bit 0 is the direction (1 = write), bit 1 selects operand versus control
  typedef enum logic [1:0] {
    KIND_CTLRD = 2'b00,
    KIND_OPWR  = 2'b01,
    KIND_DATRD = 2'b10,
    KIND_DATWR = 2'b11
  } xfer_kind_e;

  function automatic logic kind_is_read(input xfer_kind_e k);
    return (k[0] == 1'b0);
  endfunction

endpackage

// File: rtl/cpbus_decode.sv
module cpbus_decode
  import cpbus_pkg::*;
(
  input  logic       stack_en_i,
  input  logic       sel_lo_n_i,
  input  logic       sel_hi_i,
  input  logic       fn_cmd_i,
  input  logic       fn_wr_i,
  output logic       sel_ok_o,
  output xfer_kind_e kind_o
);

  always_comb begin
    sel_ok_o = stack_en_i & ~sel_lo_n_i & sel_hi_i;
    kind_o   = xfer_kind_e'({fn_cmd_i, fn_wr_i});
  end

endmodule

// File: rtl/cpbus_cycle.sv
module cpbus_cycle
  import cpbus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       sel_ok_i,
  input  xfer_kind_e kind_i,
  output logic       active_o,
  output xfer_kind_e kind_o,
  output logic       close_o
);

  logic       active_q, active_d;
  xfer_kind_e kind_q, kind_d;
  logic       open_en;

  always_comb begin
    open_en  = ~active_q & start_i & sel_ok_i;
    close_o  = active_q & done_i;
    active_d = active_q;
    kind_d   = kind_q;
    if (open_en) begin
      active_d = 1'b1;
      kind_d   = kind_i;
    end else if (close_o) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= KIND_CTLRD;
    end else begin
      active_q <= active_d;
      kind_q   <= kind_d;
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;

  // R2: a cycle never opens without a valid select
  p_open_needs_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !(start_i && sel_ok_i)) |=> !active_q);

  // R3: captured kind holds while the cycle stays open
  p_kind_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !done_i) |=> (active_q && $stable(kind_q)));

  // R4: end strobe closes an open cycle
  p_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && done_i) |=> !active_q);

endmodule

// File: rtl/cpbus_sync.sv
module cpbus_sync
  import cpbus_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             close_i,
  input  xfer_kind_e       kind_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [CNT_W-1:0] opnd_need_i,
  input  logic             exec_done_i,
  input  logic             fifo_rdy_i,
  output logic             busy_o,
  output logic             opnd_req_o,
  output logic             proto_err_o,
  output logic             op_vld_o,
  output logic [DW-1:0]    op_word_o,
  output logic             push_o,
  output logic [DW-1:0]    push_word_o,
  output logic             pop_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] words_q, words_d;
  logic             err_q, err_d;
  logic             op_vld_q, push_q, pop_q;
  logic [DW-1:0]    op_word_q, push_word_q;
  logic             op_fire, op_ok, op_bad, rd_fire, wr_fire, dat_fire;

  always_comb begin
    op_fire  = close_i & (kind_i == KIND_OPWR);
    op_ok    = op_fire & ~busy_q;
    op_bad   = op_fire & busy_q;
    rd_fire  = close_i & (kind_i == KIND_DATRD);
    wr_fire  = close_i & (kind_i == KIND_DATWR);
    dat_fire = rd_fire | wr_fire;

    busy_d = busy_q;
    if (op_ok)            busy_d = 1'b1;
    else if (exec_done_i) busy_d = 1'b0;

    words_d = words_q;
    if (op_ok)                                words_d = opnd_need_i;
    else if (dat_fire && words_q != CNT_ZERO) words_d = words_q - CNT_ONE;

    err_d = err_q | op_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      words_q  <= CNT_ZERO;
      err_q    <= 1'b0;
      op_vld_q <= 1'b0;
      push_q   <= 1'b0;
      pop_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      words_q  <= words_d;
      err_q    <= err_d;
      op_vld_q <= op_ok;
      push_q   <= wr_fire;
      pop_q    <= rd_fire;
    end
  end

  // Data holding registers with explicit load enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_word_q   <= '0;
      push_word_q <= '0;
    end else begin
      if (op_ok)   op_word_q   <= wr_data_i;
      if (wr_fire) push_word_q <= wr_data_i;
    end
  end

  assign busy_o      = busy_q;
  assign opnd_req_o  = (words_q != CNT_ZERO) & fifo_rdy_i;
  assign proto_err_o = err_q;
  assign op_vld_o    = op_vld_q;
  assign op_word_o   = op_word_q;
  assign push_o      = push_q;
  assign push_word_o = push_word_q;
  assign pop_o       = pop_q;

  // R6: busy only rises after an opcode write closes
  p_busy_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(close_i && kind_i == KIND_OPWR));

  // R7: completion drops busy unless a new opcode is accepted
  p_busy_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && exec_done_i) |=> !busy_q);

  // R8: each operand transfer consumes one outstanding word
  p_words_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && kind_i[1] && words_q != CNT_ZERO)
      |=> (words_q == $past(words_q) - CNT_ONE));

  // R10: opcode while busy is dropped and flagged
  p_busy_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && kind_i == KIND_OPWR && busy_q) |=> (!op_vld_q && err_q));

  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

endmodule

// File: rtl/cpbus_slave.sv
module cpbus_slave
  import cpbus_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stack_en_i,
  input  logic             sel_lo_n_i,
  input  logic             sel_hi_i,
  input  logic             fn_cmd_i,
  input  logic             fn_wr_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             data_oe_o,
  output logic             ctl_oe_o,
  input  logic [DW-1:0]    stat_word_i,
  input  logic [DW-1:0]    fifo_word_i,
  input  logic             fifo_rdy_i,
  input  logic [CNT_W-1:0] opnd_need_i,
  input  logic             exec_done_i,
  output logic [DW-1:0]    op_word_o,
  output logic             op_vld_o,
  output logic [DW-1:0]    push_word_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             busy_o,
  output logic             opnd_req_o,
  output logic             proto_err_o
);

  logic       sel_ok;
  xfer_kind_e kind_in, kind_cur;
  logic       active, close;

  cpbus_decode u_decode (
    .stack_en_i (stack_en_i),
    .sel_lo_n_i (sel_lo_n_i),
    .sel_hi_i   (sel_hi_i),
    .fn_cmd_i   (fn_cmd_i),
    .fn_wr_i    (fn_wr_i),
    .sel_ok_o   (sel_ok),
    .kind_o     (kind_in)
  );

  cpbus_cycle u_cycle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .done_i   (done_i),
    .sel_ok_i (sel_ok),
    .kind_i   (kind_in),
    .active_o (active),
    .kind_o   (kind_cur),
    .close_o  (close)
  );

  cpbus_sync #(.DW(DW), .CNT_W(CNT_W)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .close_i     (close),
    .kind_i      (kind_cur),
    .wr_data_i   (wr_data_i),
    .opnd_need_i (opnd_need_i),
    .exec_done_i (exec_done_i),
    .fifo_rdy_i  (fifo_rdy_i),
    .busy_o      (busy_o),
    .opnd_req_o  (opnd_req_o),
    .proto_err_o (proto_err_o),
    .op_vld_o    (op_vld_o),
    .op_word_o   (op_word_o),
    .push_o      (push_o),
    .push_word_o (push_word_o),
    .pop_o       (pop_o)
  );

  // Pad enables and read source
  always_comb begin
    ctl_oe_o  = stack_en_i;
    data_oe_o = stack_en_i & active & kind_is_read(kind_cur);
    rd_data_o = '0;
    if (data_oe_o)
      rd_data_o = (kind_cur == KIND_CTLRD) ? stat_word_i : fifo_word_i;
  end

  // R1: stack disable floats everything
  p_float_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stack_en_i |-> (!ctl_oe_o && !data_oe_o));

  // R5: bus drive begins only after an accepted start strobe
  p_drive_after_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && $past(stack_en_i)) |-> $past(start_i && sel_ok));

endmodule

// File: tb/test_cpbus_slave.sv
`timescale 1ns/1ps
module test_cpbus_slave;

  localparam int DW = 32;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic          stack_en, sel_lo_n, sel_hi, fn_cmd, fn_wr, start, done;
  logic [DW-1:0] wr_data, rd_data, stat_word, fifo_word, op_word, push_word;
  logic          data_oe, ctl_oe, fifo_rdy, exec_done;
  logic [CW-1:0] opnd_need;
  logic          op_vld, push, pop, busy, opnd_req, proto_err;

  cpbus_slave #(.DW(DW), .CNT_W(CW)) i_cpbus_slave (
    .clk_i(clk), .rst_ni(rst_ni), .stack_en_i(stack_en), .sel_lo_n_i(sel_lo_n),
    .sel_hi_i(sel_hi), .fn_cmd_i(fn_cmd), .fn_wr_i(fn_wr), .start_i(start),
    .done_i(done), .wr_data_i(wr_data), .rd_data_o(rd_data), .data_oe_o(data_oe),
    .ctl_oe_o(ctl_oe), .stat_word_i(stat_word), .fifo_word_i(fifo_word),
    .fifo_rdy_i(fifo_rdy), .opnd_need_i(opnd_need), .exec_done_i(exec_done),
    .op_word_o(op_word), .op_vld_o(op_vld), .push_word_o(push_word), .push_o(push),
    .pop_o(pop), .busy_o(busy), .opnd_req_o(opnd_req), .proto_err_o(proto_err)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  bit m_busy = 0, m_err = 0;
  int m_words = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=%0d expected<50000", cyc);
      report();
    end
  end

  task automatic check_handshake(input string tag);
    chk({tag, " R6 busy"}, DW'(busy), DW'(m_busy));
    chk({tag, " R10 proto_err"}, DW'(proto_err), DW'(m_err));
    chk({tag, " R9 opnd_req"}, DW'(opnd_req), DW'((m_words != 0) && fifo_rdy));
  endtask

  // One bus cycle: start strobe, waits, end strobe, post-close checks
  task automatic bus_cycle(input logic sten, slo, shi, cmd, wr,
                           input logic [DW-1:0] wd, input int waits, input string tag);
    logic sel, exp_op, exp_bad, is_rd;
    sel   = sten && !slo && shi;
    is_rd = sel && !wr;
    stack_en = sten; sel_lo_n = slo; sel_hi = shi; fn_cmd = cmd; fn_wr = wr;
    wr_data = wd; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int w = 0; w <= waits; w++) begin
      chk({tag, " R1 ctl_oe"}, DW'(ctl_oe), DW'(sten));
      chk({tag, " R5 data_oe"}, DW'(data_oe), DW'(is_rd));
      if (is_rd) chk({tag, " R5 R3 rd_data"}, rd_data, cmd ? fifo_word : stat_word);
      if (w == waits) done = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    done = 1'b0;
    exp_op  = sel && !cmd && wr && !m_busy;
    exp_bad = sel && !cmd && wr && m_busy;
    chk({tag, " R2 R6 op_vld"}, DW'(op_vld), DW'(exp_op));
    if (exp_op) chk({tag, " R6 op_word"}, op_word, wd);
    chk({tag, " R2 R8 push"}, DW'(push), DW'(sel && cmd && wr));
    if (sel && cmd && wr) chk({tag, " R8 push_word"}, push_word, wd);
    chk({tag, " R2 R8 pop"}, DW'(pop), DW'(sel && cmd && !wr));
    chk({tag, " R4 data_oe closed"}, DW'(data_oe), 32'd0);
    if (exp_op) begin m_busy = 1; m_words = int'(opnd_need); end
    if (exp_bad) m_err = 1;
    if (sel && cmd && m_words > 0) m_words--;
    check_handshake(tag);
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 op_vld one cycle"}, DW'(op_vld | push | pop), 32'd0);
  endtask

  task automatic finish_exec(input string tag);
    exec_done = 1'b1;
    @(posedge clk); @(negedge clk);
    exec_done = 1'b0;
    m_busy = 0;
    chk({tag, " R7 busy falls"}, DW'(busy), 32'd0);
  endtask

  initial begin
    rst_ni = 1'b0;
    stack_en = 0; sel_lo_n = 1; sel_hi = 0; fn_cmd = 0; fn_wr = 0; start = 0; done = 0;
    wr_data = '0; stat_word = 32'h5A7C_0001; fifo_word = 32'hF1F0_0002;
    fifo_rdy = 1; opnd_need = '0; exec_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", DW'(busy), 0);
    chk("R11 opnd_req", DW'(opnd_req), 0);
    chk("R11 proto_err", DW'(proto_err), 0);
    chk("R11 pulses", DW'(op_vld | push | pop), 0);
    chk("R11 data_oe", DW'(data_oe), 0);
    chk("R1 ctl_oe low", DW'(ctl_oe), 0);

    // Sweep all select/function patterns (R1 R2 R3 R5 R6 R8)
    for (int c = 0; c < 32; c++) begin
      stat_word = 32'h5A7C_0000 | c;
      fifo_word = 32'hF1F0_0000 | (c << 4);
      bus_cycle(c[4], c[3], c[2], c[1], c[0], 32'hA500_0000 + c, c % 3, "sweep");
      if (m_busy) finish_exec("sweep");
    end

    // R3: function lines changed mid-cycle are ignored
    stack_en = 1; sel_lo_n = 0; sel_hi = 1; fn_cmd = 0; fn_wr = 0; start = 1;
    @(posedge clk); @(negedge clk);
    start = 0; fn_cmd = 1; fn_wr = 1;
    chk("R3 hold data_oe", DW'(data_oe), 1);
    chk("R3 hold rd_data", rd_data, stat_word);
    done = 1;
    @(posedge clk); @(negedge clk);
    done = 0;
    chk("R3 hold no push", DW'(push), 0);
    chk("R3 hold no pop", DW'(pop), 0);

    // R4: stray end strobe with no open cycle
    @(negedge clk) done = 1; fn_cmd = 0; fn_wr = 1;
    @(posedge clk); @(negedge clk);
    done = 0;
    chk("R4 stray done", DW'(op_vld | push | pop | busy), 0);

    // R1: stack enable dropped inside an open read cycle
    fn_cmd = 1; fn_wr = 0; start = 1;
    @(posedge clk); @(negedge clk);
    start = 0; stack_en = 0;
    #1;
    chk("R1 float data_oe", DW'(data_oe), 0);
    chk("R1 float ctl_oe", DW'(ctl_oe), 0);
    stack_en = 1;
    #1;
    chk("R1 restore data_oe", DW'(data_oe), 1);
    done = 1;
    @(posedge clk); @(negedge clk);
    done = 0;
    chk("R1 R8 pop after restore", DW'(pop), 1);

    // R9/R8: operand counting
    opnd_need = 3'd2; fifo_rdy = 1;
    bus_cycle(1, 0, 1, 0, 1, 32'hC0DE_0001, 1, "opnd");
    chk("R9 req with words", DW'(opnd_req), 1);
    bus_cycle(1, 0, 1, 1, 1, 32'hD00D_0002, 0, "opnd");
    fifo_rdy = 0; #1;
    chk("R9 req gated by fifo", DW'(opnd_req), 0);
    fifo_rdy = 1; #1;
    chk("R9 req back", DW'(opnd_req), 1);
    bus_cycle(1, 0, 1, 1, 0, 32'h0, 2, "opnd");
    chk("R9 req drained", DW'(opnd_req), 0);
    bus_cycle(1, 0, 1, 1, 1, 32'hD00D_0003, 0, "opnd-extra");

    // R10: opcode write while busy
    opnd_need = 3'd3;
    bus_cycle(1, 0, 1, 0, 1, 32'hBAD0_0004, 0, "busy-op");
    chk("R10 err set", DW'(proto_err), 1);
    chk("R10 count unchanged", DW'(opnd_req), 0);
    finish_exec("busy-op");
    repeat (2) @(negedge clk);
    chk("R10 err sticky", DW'(proto_err), 1);

    report();
  end

endmodule